// File: doc/BRIEF.md
# Banked Register-to-Lane Operand Router

This block connects a unified register file, split into four equal banks, to the operand inputs of four ALU lanes. Each lane has two source ports, so eight operands are routed at once. Integer and floating-point values share the same register space, so one routing network serves both. Every operand is 64 bits wide, which is enough for double-precision values or packed SIMD data.

Each operand port supplies a 7-bit register index. The two upper bits pick a bank and the five lower bits pick an entry within it. The selection is a plain 4:1 multiplexer driven directly by the two bank bits. There is no priority logic and no arbitration on the data path.

For each bank, the block drives the read entry and a read enable toward the storage. It then routes the returned bank data to every port that named that bank. Index 0 is the constant-zero register. It places no demand on any bank and always yields zero. If two ports need different entries of the same bank in one cycle, a conflict flag is raised. An optional output register, on by default, adds one cycle of latency to the operands and the flag.

Top module: `banked_operand_router`

## Requirements
- R1: Operand port k (lane k/2, port k%2) takes its index from `req_idx[7k+6:7k]`. Bits [6:5] of that index select bank b. One clock after the request, `opnd[64k+63:64k]` equals `bank_rd_data[64b+63:64b]` as it was in the request cycle.
- R2: A port whose index is 0 receives an all-zero operand one cycle later. This holds even when bank 0 is being read for another port and returns non-zero data.
- R3: In the same cycle as the request, `bank_rd_entry[5b+4:5b]` carries bits [4:0] of the index from the lowest-numbered port that has a non-zero index in bank b. `bank_rd_en[b]` is 1 exactly when such a port exists. When no port targets bank b, the entry is 0.
- R4: One cycle after the request, `conflict` is 1 exactly when two non-zero indices in the same bank name different entries. A port that loses this way receives the winner's entry data.
- R5: Ports that request the same non-zero index, or the same entry of one bank, raise no conflict and all receive identical data.
- R6: While `rst_n` is low, and in the first cycle after it is released, `opnd` is all zeros and `conflict` is 0.
- R7: When every index is 0, `bank_rd_en` is all zeros and `conflict` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| req_idx | input | 56 | Eight 7-bit register indices, port k at bits 7k+6:7k |
| bank_rd_data | input | 256 | Read data from the four banks, bank b at bits 64b+63:64b |
| bank_rd_en | output | 4 | Read demand per bank |
| bank_rd_entry | output | 20 | Entry address per bank, bank b at bits 5b+4:5b |
| opnd | output | 512 | Eight routed operands, port k at bits 64k+63:64k |
| conflict | output | 1 | Two ports asked for different entries of one bank |

## Verification
The bench models the banks as storage that returns a pattern unique to each (bank, entry) pair. A wrong bank select or a wrong entry therefore shows up as a wrong value. Paired ports with identical indices, one index per bank at the entry-range edges (31/32, 63/64, 95/96, 127), and index 0 mixed with live bank-0 reads separate the select decoding from the zero-register handling. Deliberate same-bank/different-entry pairs, placed both at low and at high port numbers, exercise the winner choice and the conflict flag. A stream of pseudo-random index vectors checks the one-cycle latency under back-to-back traffic.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
    localparam int RTR_LANES     = 4;
    localparam int RTR_PORTS     = 2;
    localparam int RTR_BANKS     = 4;
    localparam int RTR_DATA_W    = 64;
    localparam int RTR_IDX_W     = 7;
    localparam int RTR_SEL_W     = $clog2(RTR_BANKS);
    localparam int RTR_ENTRY_W   = RTR_IDX_W - RTR_SEL_W;
endpackage

// File: rtl/rtr_bank_pick.sv
module rtr_bank_pick #(
    parameter int NUM_OPS = 8,
    parameter int IDX_W   = 7,
    parameter int SEL_W   = 2,
    parameter int BANK_ID = 0,
    localparam int ENTRY_W = IDX_W - SEL_W
) (
    input  logic [NUM_OPS*IDX_W-1:0] req_idx,
    output logic                     rd_en,
    output logic [ENTRY_W-1:0]       rd_entry,
    output logic                     clash
);
    always_comb begin
        logic [IDX_W-1:0] idx;
        rd_en    = 1'b0;
        rd_entry = '0;
        clash    = 1'b0;
        for (int k = 0; k < NUM_OPS; k++) begin
            idx = req_idx[k*IDX_W +: IDX_W];
            if (idx != '0 && idx[IDX_W-1 -: SEL_W] == SEL_W'(BANK_ID)) begin
                if (!rd_en) begin
                    rd_en    = 1'b1;
                    rd_entry = idx[ENTRY_W-1:0];
                end else if (idx[ENTRY_W-1:0] != rd_entry) begin
                    clash = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtr_opnd_mux.sv
module rtr_opnd_mux #(
    parameter int DATA_W    = 64,
    parameter int IDX_W     = 7,
    parameter int NUM_BANKS = 4,
    localparam int SEL_W    = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS*DATA_W-1:0] bank_data,
    input  logic [IDX_W-1:0]            idx,
    output logic [DATA_W-1:0]           opnd
);
    logic [SEL_W-1:0] sel;
    assign sel = idx[IDX_W-1 -: SEL_W];

    always_comb begin
        if (idx == '0) opnd = '0;
        else           opnd = bank_data[int'(sel)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/banked_operand_router.sv
module banked_operand_router
    import rtr_pkg::*;
#(
    parameter int NUM_LANES = RTR_LANES,
    parameter int PORTS     = RTR_PORTS,
    parameter int NUM_BANKS = RTR_BANKS,
    parameter int DATA_W    = RTR_DATA_W,
    parameter int IDX_W     = RTR_IDX_W,
    parameter bit REG_OUT   = 1'b1,
    localparam int NUM_OPS  = NUM_LANES * PORTS,
    localparam int SEL_W    = $clog2(NUM_BANKS),
    localparam int ENTRY_W  = IDX_W - SEL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_OPS*IDX_W-1:0]      req_idx,
    input  logic [NUM_BANKS*DATA_W-1:0]   bank_rd_data,
    output logic [NUM_BANKS-1:0]          bank_rd_en,
    output logic [NUM_BANKS*ENTRY_W-1:0]  bank_rd_entry,
    output logic [NUM_OPS*DATA_W-1:0]     opnd,
    output logic                          conflict
);
    logic [NUM_BANKS-1:0]      bank_clash;
    logic [NUM_OPS*DATA_W-1:0] opnd_c;
    logic                      conflict_c;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rtr_bank_pick #(
            .NUM_OPS (NUM_OPS),
            .IDX_W   (IDX_W),
            .SEL_W   (SEL_W),
            .BANK_ID (b)
        ) u_pick (
            .req_idx  (req_idx),
            .rd_en    (bank_rd_en[b]),
            .rd_entry (bank_rd_entry[b*ENTRY_W +: ENTRY_W]),
            .clash    (bank_clash[b])
        );
    end

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        rtr_opnd_mux #(
            .DATA_W    (DATA_W),
            .IDX_W     (IDX_W),
            .NUM_BANKS (NUM_BANKS)
        ) u_mux (
            .bank_data (bank_rd_data),
            .idx       (req_idx[k*IDX_W +: IDX_W]),
            .opnd      (opnd_c[k*DATA_W +: DATA_W])
        );
    end

    assign conflict_c = |bank_clash;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opnd     <= '0;
                conflict <= 1'b0;
            end else begin
                opnd     <= opnd_c;
                conflict <= conflict_c;
            end
        end

        // R7
        idle_no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_idx == '0) |=> !conflict);

        for (genvar k = 0; k < NUM_OPS; k++) begin : g_chk
            // R2
            zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_idx[k*IDX_W +: IDX_W] == '0) |=> (opnd[k*DATA_W +: DATA_W] == '0));
            if (k > 0) begin : g_pair
                // R5
                same_idx_same_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (req_idx[k*IDX_W +: IDX_W] == req_idx[IDX_W-1:0])
                    |=> (opnd[k*DATA_W +: DATA_W] == opnd[DATA_W-1:0]));
            end
        end
    end else begin : g_comb
        assign opnd     = opnd_c;
        assign conflict = conflict_c;
    end

    // R7
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_idx == '0) |-> (bank_rd_en == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bchk
        // R3
        unused_bank_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_rd_en[b] |-> (bank_rd_entry[b*ENTRY_W +: ENTRY_W] == '0));
    end
endmodule

// File: tb/sim_banked_operand_router.sv
`timescale 1ns/1ps
module sim_banked_operand_router;
    localparam int NOPS = 8;
    localparam int NB   = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NOPS*7-1:0]  req_idx;
    logic [NB*64-1:0]   bank_rd_data;
    logic [NB-1:0]      bank_rd_en;
    logic [NB*5-1:0]    bank_rd_entry;
    logic [NOPS*64-1:0] opnd;
    logic               conflict;

    always #2 clk = ~clk;

    banked_operand_router u0 (
        .clk(clk), .rst_n(rst_n), .req_idx(req_idx), .bank_rd_data(bank_rd_data),
        .bank_rd_en(bank_rd_en), .bank_rd_entry(bank_rd_entry),
        .opnd(opnd), .conflict(conflict)
    );

    function automatic logic [63:0] pat(input int b, input int e);
        return {8'hB0 + 8'(b), 8'(e), 16'hC3C3 ^ 16'(e * 257), 32'h1357_9BDF + 32'(b * 37 + e)};
    endfunction

    // bank storage model
    always_comb begin
        for (int b = 0; b < NB; b++)
            bank_rd_data[b*64 +: 64] = pat(b, int'(bank_rd_entry[b*5 +: 5]));
    end

    typedef struct packed {
        logic [NOPS*64-1:0] ops;
        logic               conf;
    } exp_t;
    exp_t q[$];

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [NOPS*7-1:0] mk(input int a0, a1, a2, a3, a4, a5, a6, a7);
        return {7'(a7), 7'(a6), 7'(a5), 7'(a4), 7'(a3), 7'(a2), 7'(a1), 7'(a0)};
    endfunction

    task automatic drive(input logic [NOPS*7-1:0] v);
        logic [NB-1:0] en;
        int            ent [NB];
        logic          cf;
        exp_t          e;
        @(negedge clk);
        req_idx = v;
        en = '0; cf = 1'b0;
        for (int b = 0; b < NB; b++) ent[b] = 0;
        for (int k = 0; k < NOPS; k++) begin
            int ix, bk;
            ix = int'(v[k*7 +: 7]);
            bk = ix / 32;
            if (ix != 0) begin
                if (!en[bk]) begin en[bk] = 1'b1; ent[bk] = ix % 32; end
                else if (ent[bk] != ix % 32) cf = 1'b1;
            end
        end
        for (int k = 0; k < NOPS; k++) begin
            int ix;
            ix = int'(v[k*7 +: 7]);
            e.ops[k*64 +: 64] = (ix == 0) ? 64'h0 : pat(ix / 32, ent[ix / 32]);
        end
        e.conf = cf;
        #1;
        chk(bank_rd_en == en, (en == '0) ? "R7" : "R3", "bank_rd_en",
            64'(bank_rd_en), 64'(en));
        for (int b = 0; b < NB; b++)
            chk(int'(bank_rd_entry[b*5 +: 5]) == ent[b], "R3", "bank_rd_entry",
                64'(bank_rd_entry[b*5 +: 5]), 64'(ent[b]));
        q.push_back(e);
    endtask

    // monitor: compares registered outputs one cycle after each request
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            for (int k = 0; k < NOPS; k++)
                chk(opnd[k*64 +: 64] == e.ops[k*64 +: 64],
                    (e.ops[k*64 +: 64] == 64'h0) ? "R2" : "R1", "opnd",
                    opnd[k*64 +: 64], e.ops[k*64 +: 64]);
            chk(conflict == e.conf, "R4", "conflict", 64'(conflict), 64'(e.conf));
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst_n   = 1'b0;
        req_idx = '0;
        repeat (3) @(negedge clk);
        // R6: reset state
        chk(opnd == '0, "R6", "opnd in reset", opnd[63:0], 64'h0);
        chk(conflict == 1'b0, "R6", "conflict in reset", 64'(conflict), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(opnd == '0, "R6", "opnd after reset", opnd[63:0], 64'h0);
        // R1 R5: paired ports share indices, one bank per lane
        drive(mk(3, 3, 35, 35, 67, 67, 99, 99));
        // R2: index 0 next to live bank-0 reads
        drive(mk(0, 5, 0, 40, 5, 0, 70, 0));
        // R7: all zero
        drive(mk(0, 0, 0, 0, 0, 0, 0, 0));
        // R4: low-port conflict in bank 0
        drive(mk(3, 4, 0, 0, 0, 0, 0, 0));
        // R1: entry edges of every bank
        drive(mk(31, 63, 95, 127, 31, 63, 95, 127));
        // R4: high-port conflict in bank 3
        drive(mk(0, 0, 0, 0, 0, 0, 100, 101));
        // R2 R5: entry 0 of bank 1 is a real register
        drive(mk(32, 32, 0, 0, 64, 96, 0, 64));
        // R3: lowest port wins bank 2
        drive(mk(0, 0, 90, 70, 90, 0, 0, 0));
        // R1: back-to-back pseudo-random stream
        lfsr = 16'hACE1;
        for (int n = 0; n < 40; n++) begin
            logic [NOPS*7-1:0] v;
            for (int k = 0; k < NOPS; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v[k*7 +: 7] = (n % 2 == 0) ? {lfsr[6:5], 3'b000, lfsr[1:0]} : lfsr[6:0];
            end
            drive(v);
        end
        drive('0);
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R1", "pending items", 64'(q.size()), 64'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule